// File: doc/BRIEF.md
# Listen Window and Acknowledge Detector

This block follows the rectified envelope of a low-frequency tag's reply as a stream of 8-bit samples. It measures the time between successive falling edges of that envelope in carrier periods. It then matches those lengths against whole multiples of the 64-carrier-period bit time. Two timing signatures are recognised: a doubled listen window, which the tag sends before its data words, and the acknowledge the tag returns after a command. Each search is started by a one-cycle strobe and ends with a one-cycle found or timeout pulse. The block then returns to idle.

Two of the four search modes also open a command slot. After the pattern has been seen, the block waits a fixed number of bit times and probes the envelope three quarters of the way into the next bit. If that sample is neither a clear zero nor a clear one, the tag is inside a listen window. The block then pulses a request so that the transmitter sends two zero bits. Demodulation of data bits and the transmitter itself are outside this block.

Top module: `lw_ack_detect`

## Requirements
- R1: After reset, `found`, `timeout` and `req_send` are low, and they stay low while no search has been started, whatever the sample stream does.
- R2: A pulse runs from one sample below 64 (valid on a carrier tick), through a sample above 192, to the next sample below 64. Its length is the number of carrier ticks after the opening fall, up to and including the tick of the closing fall. It matches a target of N bit times when it lies within 64*N-8 to 64*N+8 inclusive, so 200 matches three bit times and 201 does not.
- R3: With `mode` = 2'b00, a 3-bit-time pulse followed by a 2-bit-time pulse and then another 3-bit-time pulse gives `found`. A non-matching pulse in the second or third place sends the search back to looking for the first pulse.
- R4: In modes 2'b00 and 2'b01, `timeout` pulses on the 500th carrier tick after `start` if the block is still waiting for the first pulse of the pattern.
- R5: With `mode` = 2'b10, two consecutive 2-bit-time pulses give `found`. While the first is still awaited, `timeout` pulses on the 256th tick after `start`.
- R6: With `mode` = 2'b01, after a 3-bit-time pulse and then a 2-bit-time pulse, the block counts 64 ticks and samples on the 112th tick after the closing fall. If that sample lies between 25 and 230 inclusive, `found` and `req_send` pulse together on the 128th tick.
- R7: In either request mode, a probe sample above 230 or below 25 gives no output, and the block resumes the search for the first pulse of its pattern, with its timeout still running from `start`.
- R8: With `mode` = 2'b11, after the two acknowledge pulses the block samples on the 176th tick after the closing fall. A sample between the thresholds gives `found` with `req_send` on the 192nd tick.
- R9: `found` and `timeout` last one clock, never occur together, and `req_send` only occurs with `found`. After either outcome the block is idle and waits for a new `start`.
- R10: Pulse lengths, the timeout and the probe delays count carrier ticks only. The number of clocks between ticks does not change any outcome.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| car_tick | input | 1 | One-clock enable per carrier period |
| env_smp | input | 8 | Envelope sample |
| env_vld | input | 1 | `env_smp` is valid this clock |
| start | input | 1 | Begin a search (accepted when idle) |
| mode | input | 2 | 00 window, 01 window + request, 10 acknowledge, 11 acknowledge + request |
| found | output | 1 | One-clock pulse: pattern recognised |
| timeout | output | 1 | One-clock pulse: search gave up |
| req_send | output | 1 | One-clock pulse: transmitter should send two zero bits |

## Verification
The window search is tried with exact lengths and with lengths at the edge of the tolerance band (200, 120, 184). It is also tried with a 201 that must miss, and with a stream that has no edges at all. Together these separate a correct tolerance band from one that is off by a tick, and a proper timeout from a hang. The acknowledge modes are tried with two good pulses and with a long first pulse followed by short ones. The request modes are tried with a mid-level probe sample, a high probe sample and a low probe sample. These show that the probe is taken at the right tick and that a clear bit sends the block back to searching. The same window stream is replayed with sparser carrier ticks, so that any dependence on clock count rather than tick count would show.

// File: rtl/lw_ack_detect.sv
module lw_ack_detect #(
  parameter int BIT_T    = 64,
  parameter int TOL      = 8,
  parameter int FIND_LIM = 500,
  parameter int ACK_BITS = 4,
  parameter int LO_TH    = 64,
  parameter int HI_TH    = 192,
  parameter int ZERO_TH  = 230,
  parameter int ONE_TH   = 25
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       car_tick,
  input  logic [7:0] env_smp,
  input  logic       env_vld,
  input  logic       start,
  input  logic [1:0] mode,
  output logic       found,
  output logic       timeout,
  output logic       req_send
);
  localparam int LIM_ACK = ACK_BITS * BIT_T;
  localparam int TMAX0   = (FIND_LIM > LIM_ACK) ? FIND_LIM : LIM_ACK;
  localparam int TMAX    = (TMAX0 > 4 * BIT_T) ? TMAX0 : 4 * BIT_T;
  localparam int TW      = $clog2(TMAX + 1) + 1;

  typedef enum logic [2:0] {S_IDLE, S_W3, S_W2, S_W3B, S_A1, S_A2, S_POST} st_t;

  st_t         st_q, st_n;
  logic [1:0]  md_q;
  logic        armed_q, hi_q, other_q;
  logic [TW-1:0] cnt_q, tmr_q, ph_q;
  logic        f_n, to_n, rq_n;

  function automatic logic near(input logic [TW-1:0] l, input int tgt);
    return (int'(l) >= tgt - TOL) && (int'(l) <= tgt + TOL);
  endfunction

  wire fall = env_vld && (env_smp < 8'(LO_TH));
  wire rise = env_vld && (env_smp > 8'(HI_TH));
  wire pev  = fall && armed_q && hi_q;
  wire [TW-1:0] plen = cnt_q + TW'(car_tick);
  wire is3 = pev && near(plen, 3 * BIT_T);
  wire is2 = pev && near(plen, 2 * BIT_T);

  wire [TW-1:0] tmr_nx = tmr_q + TW'(car_tick && (tmr_q != {TW{1'b1}}));
  wire [TW-1:0] ph_nx  = ph_q + TW'(car_tick);
  wire [TW-1:0] lim    = md_q[1] ? TW'(LIM_ACK) : TW'(FIND_LIM);
  wire [TW-1:0] skip   = md_q[1] ? TW'(2 * BIT_T) : TW'(BIT_T);
  wire pother = !(env_smp > 8'(ZERO_TH)) && !(env_smp < 8'(ONE_TH));
  wire top    = (st_q == S_W3) || (st_q == S_A1);

  always_comb begin
    st_n = st_q; f_n = 1'b0; to_n = 1'b0; rq_n = 1'b0;
    case (st_q)
      S_IDLE: if (start) st_n = mode[1] ? S_A1 : S_W3;
      S_W3:   if (is3) st_n = S_W2;
      S_W2:   if (pev) st_n = is2 ? (md_q[0] ? S_POST : S_W3B) : S_W3;
      S_W3B:  if (pev) begin
                if (is3) begin f_n = 1'b1; st_n = S_IDLE; end
                else st_n = S_W3;
              end
      S_A1:   if (is2) st_n = S_A2;
      S_A2:   if (pev) begin
                if (!is2) st_n = S_A1;
                else if (md_q[0]) st_n = S_POST;
                else begin f_n = 1'b1; st_n = S_IDLE; end
              end
      S_POST: if (car_tick && ph_nx == skip + TW'(BIT_T)) begin
                if (other_q) begin f_n = 1'b1; rq_n = 1'b1; st_n = S_IDLE; end
                else st_n = md_q[1] ? S_A1 : S_W3;
              end
      default: st_n = S_IDLE;
    endcase
    if (top && car_tick && tmr_nx >= lim && st_n == st_q) begin
      to_n = 1'b1; st_n = S_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; md_q <= 2'b00; tmr_q <= '0; ph_q <= '0; other_q <= 1'b0;
      found <= 1'b0; timeout <= 1'b0; req_send <= 1'b0;
    end else begin
      st_q <= st_n;
      found <= f_n; timeout <= to_n; req_send <= rq_n;
      if (st_q == S_IDLE && start) begin
        md_q <= mode; tmr_q <= '0;
      end else tmr_q <= tmr_nx;
      ph_q <= (st_q == S_POST) ? ph_nx : '0;
      if (st_q == S_POST && car_tick && ph_nx == skip + TW'(3 * BIT_T / 4))
        other_q <= pother;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0; hi_q <= 1'b0; cnt_q <= '0;
    end else if (st_q == S_IDLE) begin
      armed_q <= 1'b0; hi_q <= 1'b0; cnt_q <= '0;
    end else if (pev) begin
      cnt_q <= '0; hi_q <= 1'b0;
    end else if (fall && !armed_q) begin
      armed_q <= 1'b1; cnt_q <= '0;
    end else begin
      if (armed_q && car_tick && cnt_q != {TW{1'b1}}) cnt_q <= cnt_q + 1'b1;
      if (rise && armed_q) hi_q <= 1'b1;
    end
  end

  assert_no_dual_outcome_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(found && timeout));
  assert_req_needs_found_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_send |-> found);
  assert_found_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    found |=> !found);
  assert_timeout_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> !timeout);
  assert_idle_after_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (found || timeout) |-> st_q == S_IDLE);
  assert_timeout_late_R4: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> tmr_q >= lim);
  assert_tick_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!car_tick && st_q != S_IDLE) |=> $stable(tmr_q));
endmodule

// File: tb/lw_ack_detect_tb_top.sv
module lw_ack_detect_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, car_tick = 1'b0, env_vld = 1'b0, start = 1'b0;
  logic [7:0] env_smp = 8'd0;
  logic [1:0] mode = 2'b00;
  logic found, timeout, req_send;

  lw_ack_detect dut_i (.clk(clk), .rst_n(rst_n), .car_tick(car_tick), .env_smp(env_smp),
    .env_vld(env_vld), .start(start), .mode(mode), .found(found), .timeout(timeout),
    .req_send(req_send));

  int vectors = 0, miscompares = 0, nf, nt, nr, cycles = 0;
  string tag = "R1";
  int q[$];
  bit ef, et, er;
  int m_st = 0, m_md, m_arm, m_hi, m_cnt, m_tmr, m_ph, m_oth;

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      miscompares++;
      $display("FAIL watchdog (%s): run did not end, cycles=%0d expected below 150000", tag, cycles);
      summary();
    end
  end

  // behavioural reference, evaluated once per clock; result visible after the edge
  task automatic model(bit tk, int s, bit stt, int md);
    int len, skip, lim;
    bit ev, i2, i3;
    ef = 0; et = 0; er = 0;
    if (m_st == 0) begin
      if (stt) begin
        m_md = md; m_st = (md >= 2) ? 4 : 1;
        m_tmr = 0; m_arm = 0; m_hi = 0; m_cnt = 0; m_ph = 0;
      end
      return;
    end
    if (!tk) return;
    ev = 0; len = 0; m_tmr++;
    if (s < 64) begin
      if (m_arm && m_hi) begin ev = 1; len = m_cnt + 1; m_cnt = 0; m_hi = 0; end
      else if (!m_arm) begin m_arm = 1; m_cnt = 0; end
      else m_cnt++;
    end else if (m_arm) begin
      m_cnt++;
      if (s > 192) m_hi = 1;
    end
    i3 = ev && len >= 184 && len <= 200;
    i2 = ev && len >= 120 && len <= 136;
    skip = (m_md >= 2) ? 128 : 64;
    lim  = (m_md >= 2) ? 256 : 500;
    case (m_st)
      1: if (i3) m_st = 2; else if (m_tmr >= lim) begin et = 1; m_st = 0; end
      2: if (ev) begin
           if (i2) begin m_st = (m_md == 1) ? 6 : 3; m_ph = 0; end
           else m_st = 1;
         end
      3: if (ev) begin
           if (i3) begin ef = 1; m_st = 0; end else m_st = 1;
         end
      4: if (i2) m_st = 5; else if (m_tmr >= lim) begin et = 1; m_st = 0; end
      5: if (ev) begin
           if (!i2) m_st = 4;
           else if (m_md == 3) begin m_st = 6; m_ph = 0; end
           else begin ef = 1; m_st = 0; end
         end
      6: begin
           m_ph++;
           if (m_ph == skip + 48) m_oth = (s <= 230 && s >= 25) ? 1 : 0;
           if (m_ph == skip + 64) begin
             if (m_oth != 0) begin ef = 1; er = 1; m_st = 0; end
             else m_st = (m_md >= 2) ? 4 : 1;
           end
         end
      default: m_st = 0;
    endcase
  endtask

  task automatic cyc(bit tk, int s, bit stt, int md);
    @(negedge clk);
    vectors++;
    if ({found, timeout, req_send} !== {ef, et, er}) begin
      miscompares++;
      $display("FAIL %s: found/timeout/req_send=%b%b%b expected %b%b%b at cycle %0d",
               tag, found, timeout, req_send, ef, et, er, cycles);
    end
    nf += int'(found); nt += int'(timeout); nr += int'(req_send);
    car_tick = tk; env_vld = tk; env_smp = 8'(s); start = stt; mode = 2'(md);
    model(tk, s, stt, md);
  endtask

  task automatic pulse(int len);
    for (int k = 0; k < len - 1; k++) q.push_back(250);
    q.push_back(10);
  endtask

  task automatic fill(int v, int n);
    for (int k = 0; k < n; k++) q.push_back(v);
  endtask

  task automatic run(string t, int md, bit go, int g, int xf, int xt, int xr);
    tag = t; nf = 0; nt = 0; nr = 0;
    cyc(0, 0, go, md);
    foreach (q[i]) begin
      for (int k = 0; k <= (i % g); k++) cyc(0, 0, 0, md);
      cyc(1, q[i], 0, md);
    end
    repeat (8) cyc(0, 0, 0, md);
    vectors++;
    if (nf != xf || nt != xt || nr != xr) begin
      miscompares++;
      $display("FAIL %s: outcome counts found/timeout/req=%0d/%0d/%0d expected %0d/%0d/%0d",
               t, nf, nt, nr, xf, xt, xr);
    end
    q.delete();
  endtask

  initial begin
    repeat (3) cyc(0, 0, 0, 0);
    rst_n = 1'b1;
    repeat (3) cyc(0, 0, 0, 0);
    // R1: stream without start
    fill(10, 1); pulse(192); pulse(128); pulse(192); fill(128, 10);
    run("R1", 0, 0, 2, 0, 0, 0);
    // R3: exact double window
    fill(10, 1); pulse(192); pulse(128); pulse(192); fill(128, 20);
    run("R3", 0, 1, 2, 1, 0, 0);
    // R2: tolerance edges accepted
    fill(10, 1); pulse(200); pulse(120); pulse(184); fill(128, 20);
    run("R2", 0, 1, 2, 1, 0, 0);
    // R2/R4: 201 misses, search times out
    fill(10, 1); pulse(201); pulse(128); for (int k = 0; k < 4; k++) pulse(100);
    run("R2", 0, 1, 2, 0, 1, 0);
    // R4: no edges at all
    fill(128, 520);
    run("R4", 0, 1, 2, 0, 1, 0);
    // R5: acknowledge found, then acknowledge timeout
    fill(10, 1); pulse(120); pulse(136); fill(128, 20);
    run("R5", 2, 1, 2, 1, 0, 0);
    fill(10, 1); pulse(192); for (int k = 0; k < 5; k++) pulse(64);
    run("R5", 2, 1, 2, 0, 1, 0);
    // R6: command slot with mid-level probe
    fill(10, 1); pulse(192); pulse(128); fill(128, 140);
    run("R6", 1, 1, 2, 1, 0, 1);
    // R7: probe reads a clear zero, then a clear one
    fill(10, 1); pulse(192); pulse(128); fill(250, 300);
    run("R7", 1, 1, 2, 0, 1, 0);
    fill(10, 1); pulse(192); pulse(128); fill(10, 300);
    run("R7", 1, 1, 2, 0, 1, 0);
    // R8: acknowledge then request, and the clear-bit variant
    fill(10, 1); pulse(128); pulse(128); fill(128, 250);
    run("R8", 3, 1, 2, 1, 0, 1);
    fill(10, 1); pulse(128); pulse(128); fill(250, 300);
    run("R8", 3, 1, 2, 0, 1, 0);
    // R10: same window stream with sparser ticks
    fill(10, 1); pulse(192); pulse(128); pulse(192); fill(128, 20);
    run("R10", 0, 1, 5, 1, 0, 0);
    fill(10, 1); pulse(192); pulse(128); fill(128, 140);
    run("R10", 1, 1, 4, 1, 0, 1);
    // R9: new search accepted right after an outcome
    fill(10, 1); pulse(128); pulse(128); fill(128, 10);
    run("R9", 2, 1, 1, 1, 0, 0);
    summary();
  end
endmodule